// File: doc/BRIEF.md
# Iterative Signed/Unsigned Divide and Remainder Unit

This unit carries out integer division and remainder for a register-based instruction set. It handles a 32-bit arithmetic class and a 64-bit arithmetic class, and each can run as signed or unsigned. The caller presents the dividend, which comes from the destination register. It also presents a divisor, taken either from a source register or from a 32-bit immediate. Three controls complete the request: the class, whether the remainder is wanted, and the signed flag. A one-cycle `start_i` pulse then launches the operation.

The datapath uses restoring shift-subtract and resolves one quotient bit per clock. A 32-bit operation takes 32 steps and a 64-bit operation takes 64 steps. Signed operands are reduced to magnitudes first, and the signs are applied again at the end. A zero divisor skips the iteration and returns at once. While an operation is in flight, `busy_o` stays high and any new start is dropped. The answer appears on `result_o` for the single cycle in which `done_o` is high.

Top module: `divmod_unit`

## Requirements
- R1: With `signed_i`=0, `rem_i`=0 and a nonzero divisor, `result_o` is the unsigned quotient, truncated. In the 64-bit class (`wide_i`=1) all 64 bits take part.
- R2: In the 32-bit class (`wide_i`=0) only bits 31:0 of the dividend and of a register divisor are used, and bits 63:32 of every result, including the zero-divisor results, are 0.
- R3: When the divisor is zero and `rem_i`=0, the result is 0.
- R4: When the divisor is zero and `rem_i`=1, the result is the dividend unchanged, with bits 63:32 cleared in the 32-bit class.
- R5: With `signed_i`=1 the quotient is rounded toward zero and the remainder carries the sign of the dividend, so -13 rem 3 = -1 and -13 div 3 = -4.
- R6: The most negative dividend of the class divided by -1 gives that same most negative value as quotient and 0 as remainder.
- R7: With `imm_sel_i`=1 the divisor is `divisor_imm_i`. The 32-bit class uses it as a 32-bit value, and the 64-bit class sign-extends it to 64 bits first. In both cases the signed flag then decides how it is interpreted.
- R8: The rising edge that accepts the start counts as edge 1. `done_o` goes high after edge 34 for a 32-bit operation and after edge 66 for a 64-bit operation. With a zero divisor it goes high after edge 1.
- R9: `busy_o` is high from an accepted nonzero-divisor start until `done_o`. A `start_i` seen while `busy_o` is high is ignored: it does not change the result in flight and produces no second `done_o`.
- R10: `done_o` is a one-cycle pulse for each accepted operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch request, accepted when `busy_o` is low |
| wide_i | input | 1 | 1 = 64-bit class, 0 = 32-bit class |
| rem_i | input | 1 | 1 = return remainder, 0 = return quotient |
| signed_i | input | 1 | 1 = signed operands |
| imm_sel_i | input | 1 | 1 = divisor from immediate, 0 = from register |
| dividend_i | input | 64 | Destination register value |
| divisor_reg_i | input | 64 | Source register value |
| divisor_imm_i | input | 32 | Immediate field |
| busy_o | output | 1 | Iteration in progress |
| done_o | output | 1 | Result valid pulse |
| result_o | output | 64 | Quotient or remainder |

## Verification
The bench targets four kinds of case:
- **Sign fix-up.** It uses -13 by 3 and mixed-sign pairs. A unit that floors instead of truncating would return 2 for the remainder, and one that takes the remainder's sign from the divisor would flip it.
- **Overflow.** It checks the most negative value divided by -1 in both classes. Without wrap handling the quotient would come out with a wrong sign bit, or the remainder would be nonzero.
- **Zero divisor.** It checks both outputs in both classes. A shared path would leak the dividend's upper half in 32-bit remainders or return all-ones quotients.
- **Immediate extension and timing.** Immediate divisors with bit 31 set separate sign-extension from zero-extension. Exact cycle counts and a start sent mid-operation expose off-by-one iteration counts and starts that are not blocked.

// File: rtl/divmod_pkg.sv
package divmod_pkg;
  localparam int unsigned DM_XLEN = 64;
  localparam int unsigned DM_HALF = DM_XLEN / 2;

  typedef logic [DM_XLEN-1:0] dm_word_t;

  // two's complement negation over the full word
  function automatic dm_word_t dm_negate(input dm_word_t v);
    return ~v + dm_word_t'(1);
  endfunction

  // clear the upper half, keeping the 32-bit class view
  function automatic dm_word_t dm_low_half(input dm_word_t v);
    return {{DM_HALF{1'b0}}, v[DM_HALF-1:0]};
  endfunction

  // magnitude of a value whose sign is given separately
  function automatic dm_word_t dm_magnitude(input dm_word_t v, input logic neg, input logic wide);
    dm_word_t m;
    m = neg ? dm_negate(v) : v;
    return wide ? m : dm_low_half(m);
  endfunction

  // reapply a sign to a magnitude and fit it to the class
  function automatic dm_word_t dm_apply_sign(input dm_word_t mag, input logic neg, input logic wide);
    dm_word_t s;
    s = neg ? dm_negate(mag) : mag;
    return wide ? s : dm_low_half(s);
  endfunction
endpackage

// File: rtl/divmod_prep.sv
module divmod_prep
  import divmod_pkg::*;
(
  input  logic     wide_i,
  input  logic     signed_i,
  input  logic     imm_sel_i,
  input  dm_word_t dividend_i,
  input  dm_word_t divisor_reg_i,
  input  logic [DM_HALF-1:0] divisor_imm_i,
  output dm_word_t dividend_norm_o,
  output dm_word_t dividend_mag_o,
  output dm_word_t divisor_mag_o,
  output logic     dividend_neg_o,
  output logic     quotient_neg_o,
  output logic     divisor_zero_o
);
  dm_word_t imm_ext, divisor_norm;
  logic     a_sign, b_sign, b_neg;

  always_comb begin
    imm_ext = wide_i ? {{DM_HALF{divisor_imm_i[DM_HALF-1]}}, divisor_imm_i}
                     : {{DM_HALF{1'b0}}, divisor_imm_i};
    dividend_norm_o = wide_i ? dividend_i : dm_low_half(dividend_i);
    divisor_norm    = imm_sel_i ? imm_ext
                    : (wide_i ? divisor_reg_i : dm_low_half(divisor_reg_i));
    a_sign = wide_i ? dividend_norm_o[DM_XLEN-1] : dividend_norm_o[DM_HALF-1];
    b_sign = wide_i ? divisor_norm[DM_XLEN-1]    : divisor_norm[DM_HALF-1];
    dividend_neg_o = signed_i & a_sign;
    b_neg          = signed_i & b_sign;
    quotient_neg_o = dividend_neg_o ^ b_neg;
    dividend_mag_o = dm_magnitude(dividend_norm_o, dividend_neg_o, wide_i);
    divisor_mag_o  = dm_magnitude(divisor_norm, b_neg, wide_i);
    divisor_zero_o = (divisor_norm == '0);
  end
endmodule

// File: rtl/divmod_core.sv
module divmod_core
  import divmod_pkg::*;
#(
  parameter int unsigned XLEN = DM_XLEN,
  parameter int unsigned HALF = XLEN / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic            wide_i,
  input  logic [XLEN-1:0] dividend_mag_i,
  input  logic [XLEN-1:0] divisor_mag_i,
  output logic            busy_o,
  output logic            last_o,
  output logic [XLEN-1:0] quotient_o,
  output logic [XLEN-1:0] remainder_o
);
  localparam int unsigned CW = $clog2(XLEN + 1);

  logic [XLEN-1:0] acc_q, quo_q, dvs_q;
  logic [CW-1:0]   cnt_q;
  logic            busy_q;
  logic [XLEN:0]   shifted, trial;
  logic            fits;
  logic            stepping;

  always_comb begin
    shifted  = {acc_q, quo_q[XLEN-1]};
    trial    = shifted - {1'b0, dvs_q};
    fits     = ~trial[XLEN];
    stepping = busy_q && (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      acc_q  <= '0;
      quo_q  <= wide_i ? dividend_mag_i : (dividend_mag_i << HALF);
      dvs_q  <= divisor_mag_i;
      cnt_q  <= wide_i ? CW'(XLEN) : CW'(HALF);
      busy_q <= 1'b1;
    end else if (stepping) begin
      acc_q <= fits ? trial[XLEN-1:0] : shifted[XLEN-1:0];
      quo_q <= {quo_q[XLEN-2:0], fits};
      cnt_q <= cnt_q - 1'b1;
    end else if (busy_q) begin
      busy_q <= 1'b0;
    end
  end

  assign busy_o      = busy_q;
  assign last_o      = busy_q && (cnt_q == '0);
  assign quotient_o  = quo_q;
  assign remainder_o = acc_q;

  // R8
  step_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stepping && !load_i |=> cnt_q == $past(cnt_q) - 1'b1);

  // R1
  partial_rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> acc_q < dvs_q);
endmodule

// File: rtl/divmod_unit.sv
module divmod_unit
  import divmod_pkg::*;
#(
  parameter int unsigned XLEN = DM_XLEN,
  parameter int unsigned HALF = XLEN / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            wide_i,
  input  logic            rem_i,
  input  logic            signed_i,
  input  logic            imm_sel_i,
  input  logic [XLEN-1:0] dividend_i,
  input  logic [XLEN-1:0] divisor_reg_i,
  input  logic [HALF-1:0] divisor_imm_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [XLEN-1:0] result_o
);
  dm_word_t a_norm, a_mag, b_mag, quo, rem;
  logic     a_neg, q_neg, b_zero, core_busy, core_last;
  logic     accept, accept_zero, load_core;

  logic     wide_q, rem_q, a_neg_q, q_neg_q, done_q;
  dm_word_t result_q;

  divmod_prep u_prep (
    .wide_i(wide_i), .signed_i(signed_i), .imm_sel_i(imm_sel_i),
    .dividend_i(dividend_i), .divisor_reg_i(divisor_reg_i),
    .divisor_imm_i(divisor_imm_i),
    .dividend_norm_o(a_norm), .dividend_mag_o(a_mag), .divisor_mag_o(b_mag),
    .dividend_neg_o(a_neg), .quotient_neg_o(q_neg), .divisor_zero_o(b_zero)
  );

  assign accept      = start_i && !core_busy;
  assign accept_zero = accept && b_zero;
  assign load_core   = accept && !b_zero;

  divmod_core #(.XLEN(XLEN), .HALF(HALF)) u_core (
    .clk(clk), .rst_n(rst_n), .load_i(load_core), .wide_i(wide_i),
    .dividend_mag_i(a_mag), .divisor_mag_i(b_mag),
    .busy_o(core_busy), .last_o(core_last),
    .quotient_o(quo), .remainder_o(rem)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_q   <= 1'b0;
      rem_q    <= 1'b0;
      a_neg_q  <= 1'b0;
      q_neg_q  <= 1'b0;
      done_q   <= 1'b0;
      result_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        wide_q  <= wide_i;
        rem_q   <= rem_i;
        a_neg_q <= a_neg;
        q_neg_q <= q_neg;
      end
      if (accept_zero) begin
        done_q   <= 1'b1;
        result_q <= rem_i ? a_norm : '0;
      end else if (core_last) begin
        done_q   <= 1'b1;
        result_q <= rem_q ? dm_apply_sign(rem, a_neg_q, wide_q)
                          : dm_apply_sign(quo, q_neg_q, wide_q);
      end
    end
  end

  assign busy_o   = core_busy;
  assign done_o   = done_q;
  assign result_o = result_q;

  // R8
  zero_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_zero |=> done_o && !busy_o);

  // R3
  zero_quot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_zero && !rem_i |=> result_o == '0);

  // R2
  upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !wide_q |-> result_o[XLEN-1:HALF] == '0);

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !core_last |=> busy_o && !done_o);

  // R10
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
endmodule

// File: tb/divmod_unit_bench.sv
`timescale 1ns/1ps
module divmod_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, wide_i = 1'b0, rem_i = 1'b0, signed_i = 1'b0, imm_sel_i = 1'b0;
  logic [63:0] dividend_i = '0, divisor_reg_i = '0;
  logic [31:0] divisor_imm_i = '0;
  logic        busy_o, done_o;
  logic [63:0] result_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  divmod_unit u_divmod_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .wide_i(wide_i), .rem_i(rem_i),
    .signed_i(signed_i), .imm_sel_i(imm_sel_i), .dividend_i(dividend_i),
    .divisor_reg_i(divisor_reg_i), .divisor_imm_i(divisor_imm_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // reference model, written from the requirements
  function automatic logic [63:0] model(input logic w, input logic r, input logic s,
      input logic im, input logic [63:0] a, input logic [63:0] br, input logic [31:0] bi);
    longint sa, sb;
    int     ia, ib;
    logic [63:0] b64;
    logic [31:0] a32, b32;
    if (w) begin
      b64 = im ? {{32{bi[31]}}, bi} : br;
      if (b64 == 0) return r ? a : 64'd0;
      if (!s) return r ? a % b64 : a / b64;
      sa = a; sb = b64;
      if (a == 64'h8000_0000_0000_0000 && b64 == '1) return r ? 64'd0 : a;
      return r ? 64'(sa % sb) : 64'(sa / sb);
    end
    a32 = a[31:0];
    b32 = im ? bi : br[31:0];
    if (b32 == 0) return r ? {32'd0, a32} : 64'd0;
    if (!s) return {32'd0, (r ? a32 % b32 : a32 / b32)};
    ia = a32; ib = b32;
    if (a32 == 32'h8000_0000 && b32 == '1) return r ? 64'd0 : {32'd0, a32};
    return {32'd0, 32'(r ? ia % ib : ia / ib)};
  endfunction

  task automatic drive(input logic w, input logic r, input logic s, input logic im,
      input logic [63:0] a, input logic [63:0] br, input logic [31:0] bi);
    wide_i = w; rem_i = r; signed_i = s; imm_sel_i = im;
    dividend_i = a; divisor_reg_i = br; divisor_imm_i = bi;
  endtask

  // issues one op and checks result, latency and pulse width
  task automatic run_op(input string req, input logic w, input logic r, input logic s,
      input logic im, input logic [63:0] a, input logic [63:0] br, input logic [31:0] bi,
      input bit intrude);
    logic [63:0] exp;
    int lat, exp_lat;
    bit zero;
    exp  = model(w, r, s, im, a, br, bi);
    zero = w ? ((im ? {{32{bi[31]}}, bi} : br) == 0) : ((im ? bi : br[31:0]) == 0);
    exp_lat = zero ? 1 : (w ? 66 : 34);
    @(negedge clk);
    drive(w, r, s, im, a, br, bi);
    start_i = 1'b1;
    lat = 0;
    while (lat < 200) begin
      @(negedge clk);
      start_i = 1'b0;
      lat++;
      if (lat == 1 && !zero) check("R9 busy after start", {63'd0, busy_o}, 64'd1);
      if (intrude && lat == 5) begin
        drive(~w, ~r, ~s, 1'b0, 64'h77, 64'h0, 32'h0);
        start_i = 1'b1;
      end
      if (done_o) break;
    end
    check({req, " result"}, result_o, exp);
    check("R8 latency", 64'(lat), 64'(exp_lat));
    if (!w) check("R2 upper half", {32'd0, result_o[63:32]}, 64'd0);
    @(negedge clk);
    check("R10 pulse", {63'd0, done_o}, 64'd0);
    check("R9 idle after done", {63'd0, busy_o}, 64'd0);
  endtask

  task automatic t_reset;
    check("R10 reset done", {63'd0, done_o}, 64'd0);
    check("R9 reset busy", {63'd0, busy_o}, 64'd0);
    check("R1 reset result", result_o, 64'd0);
  endtask

  task automatic t_unsigned;
    run_op("R1 u64", 1, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd7, 0, 0);
    run_op("R1 u64 rem", 1, 1, 0, 0, 64'hDEAD_BEEF_1234_5678, 64'h1_0000_0003, 0, 0);
    run_op("R1 u64 small/big", 1, 0, 0, 0, 64'd5, 64'hFFFF_0000_0000_0000, 0, 0);
  endtask

  task automatic t_class32;
    run_op("R2 u32 ignores upper", 0, 0, 0, 0, 64'hFFFF_FFFF_0000_0064, 64'hAAAA_0000_0000_0007, 0, 0);
    run_op("R2 s32 rem", 0, 1, 1, 0, 64'h1_FFFF_FF9C, 64'd7, 0, 0);
  endtask

  task automatic t_zero;
    run_op("R3 div0 64", 1, 0, 1, 0, 64'h1234, 64'd0, 0, 0);
    run_op("R3 div0 32 high bits", 0, 0, 0, 0, 64'h55, 64'hFFFF_FFFF_0000_0000, 0, 0);
    run_op("R4 mod0 64", 1, 1, 1, 0, 64'h8765_4321_0FED_CBA9, 64'd0, 0, 0);
    run_op("R4 mod0 32", 0, 1, 0, 1, 64'h8765_4321_0FED_CBA9, 64'd0, 32'd0, 0);
  endtask

  task automatic t_trunc;
    run_op("R5 -13 rem 3", 1, 1, 1, 0, 64'(-13), 64'd3, 0, 0);
    run_op("R5 -13 div 3", 1, 0, 1, 0, 64'(-13), 64'd3, 0, 0);
    run_op("R5 13 rem -3 32", 0, 1, 1, 0, 64'd13, 64'hFFFF_FFFD, 0, 0);
    run_op("R5 -100 div -7 32", 0, 0, 1, 0, 64'hFFFF_FF9C, 64'hFFFF_FFF9, 0, 0);
  endtask

  task automatic t_overflow;
    run_op("R6 min/-1 64", 1, 0, 1, 0, 64'h8000_0000_0000_0000, '1, 0, 0);
    run_op("R6 min%-1 64", 1, 1, 1, 0, 64'h8000_0000_0000_0000, '1, 0, 0);
    run_op("R6 min/-1 32", 0, 0, 1, 0, 64'h8000_0000, 64'hFFFF_FFFF, 0, 0);
    run_op("R6 min%-1 32", 0, 1, 1, 0, 64'h8000_0000, 64'hFFFF_FFFF, 0, 0);
  endtask

  task automatic t_imm;
    run_op("R7 u32 imm high bit", 0, 0, 0, 1, 64'hFFFF_FFFF, 0, 32'h8000_0001, 0);
    run_op("R7 u64 imm sext", 1, 0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFE, 0, 32'hFFFF_FFFF, 0);
    run_op("R7 s64 imm", 1, 0, 1, 1, 64'd1000, 0, 32'hFFFF_FFF6, 0);
    run_op("R7 s32 imm rem", 0, 1, 1, 1, 64'd50, 0, 32'hFFFF_FFF9, 0);
  endtask

  task automatic t_busy;
    run_op("R9 start ignored 64", 1, 0, 0, 0, 64'd1_000_000_007, 64'd13, 0, 1);
    run_op("R9 start ignored 32", 0, 1, 1, 0, 64'hFFFF_FC18, 64'd9, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_unsigned;
    t_class32;
    t_zero;
    t_trunc;
    t_overflow;
    t_imm;
    t_busy;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule